// File: doc/BRIEF.md
# Core-to-System Address Lookup Table

This block sits between a processing core and the system fabric and turns each 32-bit core physical address into a 36-bit system physical address. The core address space is split into 16 MB sections. The top eight bits of a core address pick one of 256 table entries. The entry supplies the upper twelve system address bits, a destination node code and a flag that tells the cache to leave the access out of the second-level cache. The destination code can name an off-die memory controller or the on-die message buffer of some tile. The low 24 bits pass through unchanged. Any number of entries, in this table or in the tables of other cores, may point at the same system section, which is how shared message-passing regions are set up.

Lookups arrive on a valid/ready stream and leave, one cycle later, on a second valid/ready stream. The response stage is a single register. A request is accepted only when that register is empty or is being drained in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, the response must hold steady and `req_ready` is low. If a lookup hits an entry whose valid bit is clear, the block sends no response and raises `fault` for one cycle instead. Software fills the table through a plain configuration port. That port has an entry index, a write strobe and a read strobe, and read data comes back one cycle after the read strobe.

Top module: `addr_xlate_lut`

## Requirements
- R1: After reset every entry's valid bit is clear, `rsp_valid` and `fault` are low, and `req_ready` is high.
- R2: A hit returns `rsp_addr` = {entry upper bits, `req_addr[23:0]`}, so the low 24 bits pass through untouched.
- R3: The entry used for a lookup is the one indexed by `req_addr[31:24]`.
- R4: Configuration data layout: bit 21 is valid, bits [20:9] are the upper system bits [35:24], bits [8:1] are the destination code, and bit 0 is the L2-bypass flag.
- R5: A lookup accepted on a valid entry raises `rsp_valid` on the next cycle, together with that entry's destination code and bypass flag.
- R6: A lookup accepted on an invalid entry raises `fault` for exactly one cycle and produces no response.
- R7: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and the response fields stay stable.
- R8: A configuration write affects only lookups accepted in later cycles. A lookup in the same cycle as the write sees the old entry.
- R9: A configuration read returns the stored entry on `cfg_rdata`, with `cfg_rvalid` high, on the next cycle.
- R10: Two different indices programmed with the same upper bits yield the same system address for the same in-section offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | 32 | Core physical address |
| rsp_valid | output | 1 | Translated response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_addr | output | 36 | System physical address |
| rsp_dest | output | 8 | Destination node code |
| rsp_bypass | output | 1 | Leave access out of L2 |
| fault | output | 1 | One-cycle pulse on lookup of an unmapped section |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_re | input | 1 | Configuration read strobe |
| cfg_idx | input | 8 | Entry index for read or write |
| cfg_wdata | input | 22 | Entry value to write |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rdata | output | 22 | Entry value read |

## Verification
Lookups are driven with offsets at zero, at the all-ones top of a section and at mixed values. This shows that the low bits pass through and do not leak into the index. The indices used are the lowest, the highest, a middle one and an alias pair, so a wrong index slice or a mixed-up field shows up as a wrong upper part or destination. Entries that were written invalid or never written must fault. A write and a lookup in the same cycle separate registered update from bypass behaviour, and a stalled consumer shows whether the response register holds its value and refuses new work.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  parameter int CORE_AW = 32;
  parameter int SYS_AW  = 36;
  parameter int SECT_W  = 24;
  parameter int DEST_W  = 8;
  localparam int IDX_W  = CORE_AW - SECT_W;
  localparam int UP_W   = SYS_AW - SECT_W;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int ENT_W  = UP_W + DEST_W + 2;

  // Packed so that vld is the top bit and byp is bit 0.
  typedef struct packed {
    logic              vld;
    logic [UP_W-1:0]   upper;
    logic [DEST_W-1:0] dest;
    logic              byp;
  } ent_t;
endpackage

// File: rtl/xlat_table.sv
module xlat_table
  import xlat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_re,
  input  logic [IDX_W-1:0] cfg_idx,
  input  ent_t             cfg_wdata,
  input  logic [IDX_W-1:0] lk_idx,
  output ent_t             lk_ent,
  output logic             cfg_rvalid,
  output ent_t             cfg_rdata
);
  ent_t tbl_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tbl_q[i] <= '0;
    end else if (cfg_we) begin
      tbl_q[cfg_idx] <= cfg_wdata;
    end
  end

  // Lookup sees the table as it stood before this cycle's write.
  assign lk_ent = tbl_q[lk_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rvalid <= 1'b0;
      cfg_rdata  <= '0;
    end else begin
      cfg_rvalid <= cfg_re;
      if (cfg_re) cfg_rdata <= tbl_q[cfg_idx];
    end
  end

  // R8
  wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> tbl_q[$past(cfg_idx)] == $past(cfg_wdata));

  // R9
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_re |=> cfg_rvalid);
endmodule

// File: rtl/xlat_stage.sv
module xlat_stage
  import xlat_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [CORE_AW-1:0] req_addr,
  input  ent_t               ent,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [SYS_AW-1:0]  rsp_addr,
  output logic [DEST_W-1:0]  rsp_dest,
  output logic               rsp_bypass,
  output logic               fault
);
  logic fire;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_addr   <= '0;
      rsp_dest   <= '0;
      rsp_bypass <= 1'b0;
      fault      <= 1'b0;
    end else begin
      fault <= fire && !ent.vld;
      if (fire) begin
        rsp_valid <= ent.vld;
        if (ent.vld) begin
          rsp_addr   <= {ent.upper, req_addr[SECT_W-1:0]};
          rsp_dest   <= ent.dest;
          rsp_bypass <= ent.byp;
        end
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end

  // R5
  hit_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ent.vld) |=> rsp_valid);

  // R6
  miss_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !ent.vld) |=> (fault && !rsp_valid));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_dest)
                                   && $stable(rsp_bypass)));

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && ent.vld) |=> rsp_addr[SECT_W-1:0] == $past(req_addr[SECT_W-1:0]));
endmodule

// File: rtl/addr_xlate_lut.sv
module addr_xlate_lut
  import xlat_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [CORE_AW-1:0] req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [SYS_AW-1:0]  rsp_addr,
  output logic [DEST_W-1:0]  rsp_dest,
  output logic               rsp_bypass,
  output logic               fault,
  input  logic               cfg_we,
  input  logic               cfg_re,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic [ENT_W-1:0]   cfg_wdata,
  output logic               cfg_rvalid,
  output logic [ENT_W-1:0]   cfg_rdata
);
  ent_t lk_ent;
  ent_t rd_ent;
  logic [IDX_W-1:0] lk_idx;

  // R3: section index is the top slice of the core address.
  assign lk_idx = req_addr[CORE_AW-1:SECT_W];

  xlat_table u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_re     (cfg_re),
    .cfg_idx    (cfg_idx),
    .cfg_wdata  (ent_t'(cfg_wdata)),
    .lk_idx     (lk_idx),
    .lk_ent     (lk_ent),
    .cfg_rvalid (cfg_rvalid),
    .cfg_rdata  (rd_ent)
  );

  assign cfg_rdata = rd_ent;

  xlat_stage u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .ent        (lk_ent),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_addr   (rsp_addr),
    .rsp_dest   (rsp_dest),
    .rsp_bypass (rsp_bypass),
    .fault      (fault)
  );

  // R6
  fault_vs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(req_valid && !lk_ent.vld));
endmodule

// File: tb/tb_addr_xlate_lut.sv
`timescale 1ns/1ps
module tb_addr_xlate_lut;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [35:0] rsp_addr;
  logic [7:0] rsp_dest;
  logic rsp_bypass, fault;
  logic cfg_we = 1'b0, cfg_re = 1'b0;
  logic [7:0] cfg_idx = '0;
  logic [21:0] cfg_wdata = '0;
  logic cfg_rvalid;
  logic [21:0] cfg_rdata;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  addr_xlate_lut dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .rsp_dest(rsp_dest), .rsp_bypass(rsp_bypass),
    .fault(fault), .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rvalid(cfg_rvalid), .cfg_rdata(cfg_rdata)
  );

  // R4 layout: {valid, upper[11:0], dest[7:0], bypass}
  function automatic logic [21:0] mk(input logic v, input logic [11:0] up,
                                     input logic [7:0] d, input logic b);
    return {v, up, d, b};
  endfunction

  // {idx, data}
  localparam logic [29:0] CFGV [6] = '{
    {8'h00, 1'b1, 12'h000, 8'h10, 1'b0},
    {8'h01, 1'b1, 12'hABC, 8'h23, 1'b1},
    {8'h80, 1'b1, 12'hFFF, 8'h05, 1'b0},
    {8'hFF, 1'b1, 12'h123, 8'h7F, 1'b1},
    {8'h40, 1'b1, 12'hABC, 8'h23, 1'b1},
    {8'h02, 1'b0, 12'h555, 8'h11, 1'b1}
  };

  // {core addr, hit, sys addr, dest, bypass}
  localparam logic [77:0] LVEC [8] = '{
    {32'h00123456, 1'b1, 36'h000123456, 8'h10, 1'b0},
    {32'h01FFFFFF, 1'b1, 36'hABCFFFFFF, 8'h23, 1'b1},
    {32'h80000000, 1'b1, 36'hFFF000000, 8'h05, 1'b0},
    {32'hFF0000AB, 1'b1, 36'h1230000AB, 8'h7F, 1'b1},
    {32'h40FFFFFF, 1'b1, 36'hABCFFFFFF, 8'h23, 1'b1},
    {32'h02000010, 1'b0, 36'h0, 8'h00, 1'b0},
    {32'h03ABCDEF, 1'b0, 36'h0, 8'h00, 1'b0},
    {32'h00FFFFFF, 1'b1, 36'h000FFFFFF, 8'h10, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] idx, input logic [21:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] a);
    @(negedge clk); req_valid = 1'b1; req_addr = a;
    @(negedge clk); req_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    check("R1 fault", 64'(fault), 64'd0);
    check("R1 req_ready", 64'(req_ready), 64'd1);
    @(negedge clk); cfg_re = 1'b1; cfg_idx = 8'h05;
    @(negedge clk); cfg_re = 1'b0;
    check("R1 entry cleared", 64'(cfg_rdata[21]), 64'd0);
    lookup(32'h00000000);
    check("R1 lookup after reset faults", 64'(fault), 64'd1);

    for (int i = 0; i < 6; i++) cfg_write(CFGV[i][29:22], CFGV[i][21:0]);

    // R2 R3 R4 R5 R6 R10 vector walk
    for (int i = 0; i < 8; i++) begin
      lookup(LVEC[i][77:46]);
      if (LVEC[i][45]) begin
        check("R5 rsp_valid", 64'(rsp_valid), 64'd1);
        check("R2 R3 R10 rsp_addr", 64'(rsp_addr), 64'(LVEC[i][44:9]));
        check("R4 rsp_dest", 64'(rsp_dest), 64'(LVEC[i][8:1]));
        check("R4 rsp_bypass", 64'(rsp_bypass), 64'(LVEC[i][0]));
        check("R5 no fault", 64'(fault), 64'd0);
      end else begin
        check("R6 fault", 64'(fault), 64'd1);
        check("R6 no rsp", 64'(rsp_valid), 64'd0);
        @(negedge clk);
        check("R6 single pulse", 64'(fault), 64'd0);
      end
    end

    // R8 write and lookup in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 8'h05; cfg_wdata = mk(1'b1, 12'h321, 8'h44, 1'b0);
    req_valid = 1'b1; req_addr = 32'h05000001;
    @(negedge clk); cfg_we = 1'b0; req_valid = 1'b0;
    check("R8 same-cycle sees old", 64'(fault), 64'd1);
    check("R8 same-cycle no rsp", 64'(rsp_valid), 64'd0);
    lookup(32'h05000001);
    check("R8 later sees new", 64'(rsp_addr), 64'h321000001);
    check("R8 later dest", 64'(rsp_dest), 64'h44);

    // R9 configuration read-back
    @(negedge clk); cfg_re = 1'b1; cfg_idx = 8'h01;
    @(negedge clk); cfg_re = 1'b0;
    check("R9 cfg_rvalid", 64'(cfg_rvalid), 64'd1);
    check("R9 cfg_rdata", 64'(cfg_rdata), 64'(mk(1'b1, 12'hABC, 8'h23, 1'b1)));

    // R7 back-pressure
    @(negedge clk); rsp_ready = 1'b0; req_valid = 1'b1; req_addr = 32'h00000010;
    @(negedge clk); req_addr = 32'h80000000;
    check("R7 stalled req_ready", 64'(req_ready), 64'd0);
    check("R7 rsp_valid", 64'(rsp_valid), 64'd1);
    @(negedge clk);
    check("R7 addr held", 64'(rsp_addr), 64'h000000010);
    check("R7 still blocked", 64'(req_ready), 64'd0);
    rsp_ready = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    check("R7 next after drain", 64'(rsp_addr), 64'hFFF000000);
    check("R7 dest after drain", 64'(rsp_dest), 64'h05);
    @(negedge clk);
    check("R7 empty", 64'(rsp_valid), 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule